// File: doc/BRIEF.md
# Cache Control Register Unit

This unit is the register-side front end of a processor's instruction and data caches. It keeps one 32-bit control word that carries a two-bit operating state for each cache, a pair of freeze-on-interrupt enables and a number of pass-through control bits. It also answers reads of two fixed, read-only configuration words. The cache arrays, flushing and snooping hardware sit elsewhere and use the control word that this unit drives out.

Software reaches the unit over a simple 32-bit register bus with an address, a write strobe, a read strobe and an access size in bytes. Only full-word accesses are honoured. Read data comes back on the cycle after the read strobe, together with a valid flag. A one-cycle interrupt-taken pulse from the core moves each cache that is enabled and armed for freezing into the frozen state. The caches then stop updating while the handler runs.

Top module: `cache_ctl_regs`

## Requirements
- R1: While reset is high, the control word clears to zero, `rvalid` is low and `rdata` is zero.
- R2: A 32-bit write (`acc_size` = 4) to offset 0x00 stores `wdata` into the control word, except that bits 14, 15, 16, 21 and 22 are stored as zero. Every other bit, bit 23 included, is stored as written.
- R3: A 32-bit read of offset 0x04 returns 0x10220000 and a 32-bit read of offset 0x08 returns 0x18220000. Writes to either offset leave the read values and the control word unchanged.
- R4: Any access whose `acc_size` is not 4 has no effect when it is a write, and returns zero with `rvalid` high when it is a read.
- R5: Writes to any offset other than 0x00, 0x04 and 0x08 (unaligned ones included) are ignored, and reads of such offsets return zero.
- R6: Instruction-cache state is bits [1:0], encoded 00 disabled, 01 frozen, 11 enabled. On an `irq_taken` pulse with bit 4 set and bits [1:0] equal to 11, bits [1:0] become 01 on the next cycle.
- R7: Data-cache state is bits [3:2], with the same encoding. On an `irq_taken` pulse with bit 5 set and bits [3:2] equal to 11, bits [3:2] become 01 on the next cycle.
- R8: An `irq_taken` pulse leaves unchanged any cache whose state is not 11 or whose freeze enable is clear. It also leaves every other bit of the control word unchanged.
- R9: When a 32-bit control-word write and an `irq_taken` pulse fall in the same cycle, the written value (masked as in R2) is stored and no freeze is applied.
- R10: `rvalid` goes high exactly one cycle after each cycle in which `rd_en` is high, and is low with `rdata` zero otherwise. A read returns the register contents from before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the register access |
| acc_size | input | SIZE_W | Access size in bytes; 4 means a full word |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| irq_taken | input | 1 | One-cycle pulse when the core takes an interrupt |
| rdata | output | 32 | Read data, valid while `rvalid` is high |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |
| ctrl_word | output | 32 | Current control word driven to the caches |

## Verification
Two pairs of functions can fall in the same cycle. The first is a software write of the control word together with the interrupt freeze. The bench arms both caches in the enabled state and then issues a write of that same armed value in the cycle the interrupt pulse arrives. A stored 0x3F shows that the write won, while 0x35 would show that the freeze leaked through. The second pair is a read and a write of the control word in one cycle. There the returned data must be the old contents, and a read that follows must show the new ones.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  // data path width of the register bus
  localparam int DATA_W     = 32;
  // a full-word access, in bytes
  localparam int WORD_BYTES = DATA_W / 8;

  // register offsets decoded by the unit
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_ICFG = 'h04;
  localparam int OFF_DCFG = 'h08;

  // number of caches with a state field and a freeze enable
  localparam int NCACHE    = 2;
  localparam int STATE_W   = 2;
  // freeze enables start at this bit, one per cache
  localparam int FRZ_BASE  = 4;

  // bits that never store: flush requests, pending flags, burst fetch
  localparam logic [DATA_W-1:0] WR_DROP_MASK = 32'h0061_C000;

  // fixed configuration words
  localparam logic [DATA_W-1:0] ICFG_WORD = 32'h1022_0000;
  localparam logic [DATA_W-1:0] DCFG_WORD = 32'h1822_0000;

  typedef enum logic [STATE_W-1:0] {
    CST_OFF  = 2'b00,
    CST_HOLD = 2'b01,
    CST_RSVD = 2'b10,
    CST_ON   = 2'b11
  } cst_e;

  // one-hot read select
  typedef struct packed {
    logic ctrl;
    logic icfg;
    logic dcfg;
  } rsel_t;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              wr_en,
  input  logic              rd_en,
  output rsel_t             rsel,
  output logic              ctrl_we
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_ICFG = ADDR_W'(OFF_ICFG);
  localparam logic [ADDR_W-1:0] A_DCFG = ADDR_W'(OFF_DCFG);
  localparam logic [SIZE_W-1:0] S_WORD = SIZE_W'(WORD_BYTES);

  logic size_ok;
  logic hit_ctrl;
  logic hit_icfg;
  logic hit_dcfg;

  always_comb begin
    size_ok  = (acc_size == S_WORD);
    hit_ctrl = (addr == A_CTRL);
    hit_icfg = (addr == A_ICFG);
    hit_dcfg = (addr == A_DCFG);

    rsel.ctrl = rd_en & size_ok & hit_ctrl;
    rsel.icfg = rd_en & size_ok & hit_icfg;
    rsel.dcfg = rd_en & size_ok & hit_dcfg;

    // configuration offsets are read-only, so only the control word writes
    ctrl_we   = wr_en & size_ok & hit_ctrl;
  end

endmodule

// File: rtl/ccr_state.sv
module ccr_state
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_taken,
  output logic [DATA_W-1:0] ctrl_q
);

  logic [DATA_W-1:0] frz_word;
  logic [DATA_W-1:0] wr_word;

  // per-cache freeze: enabled (11) with its enable set drops to frozen (01)
  logic [NCACHE-1:0][STATE_W-1:0] st_next;

  for (genvar i = 0; i < NCACHE; i++) begin : g_cache
    logic [STATE_W-1:0] st_cur;
    logic               arm;
    always_comb begin
      st_cur = ctrl_q[i*STATE_W +: STATE_W];
      arm    = ctrl_q[FRZ_BASE + i];
      if (arm && (st_cur == CST_ON))
        st_next[i] = CST_HOLD;
      else
        st_next[i] = st_cur;
    end
  end

  always_comb begin
    frz_word = ctrl_q;
    for (int i = 0; i < NCACHE; i++) begin
      frz_word[i*STATE_W +: STATE_W] = st_next[i];
    end
    wr_word = wdata & ~WR_DROP_MASK;
  end

  // a software write takes priority over the interrupt freeze
  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (ctrl_we)
      ctrl_q <= wr_word;
    else if (irq_taken)
      ctrl_q <= frz_word;
  end

endmodule

// File: rtl/ccr_readback.sv
module ccr_readback
  import ccr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  rsel_t             rsel,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] rd_mux;

  // selects are one-hot or all zero, so an AND-OR mux suffices
  always_comb begin
    rd_mux = ({DATA_W{rsel.ctrl}} & ctrl_q)
           | ({DATA_W{rsel.icfg}} & ICFG_WORD)
           | ({DATA_W{rsel.dcfg}} & DCFG_WORD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= rd_mux;
      rvalid <= rd_en;
    end
  end

endmodule

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  input  logic              irq_taken,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic [31:0]       ctrl_word
);

  rsel_t             rsel;
  logic              ctrl_we;
  logic [DATA_W-1:0] ctrl_q;

  ccr_decode #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_decode (
    .addr     (addr),
    .acc_size (acc_size),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .ctrl_we  (ctrl_we)
  );

  ccr_state u_state (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .wdata     (wdata),
    .irq_taken (irq_taken),
    .ctrl_q    (ctrl_q)
  );

  ccr_readback u_rdbk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .rsel   (rsel),
    .ctrl_q (ctrl_q),
    .rdata  (rdata),
    .rvalid (rvalid)
  );

  assign ctrl_word = ctrl_q;

endmodule

// File: rtl/cache_ctl_regs_chk.sv
module cache_ctl_regs_chk
  import ccr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [SIZE_W-1:0] acc_size,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       wdata,
  input logic              irq_taken,
  input logic [31:0]       rdata,
  input logic              rvalid,
  input logic [31:0]       ctrl_word
);

  logic word_acc;
  logic wr_ctl;
  assign word_acc = (acc_size == SIZE_W'(WORD_BYTES));
  assign wr_ctl   = wr_en && word_acc && (addr == ADDR_W'(OFF_CTRL));

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (ctrl_word == 32'h0 && !rvalid && rdata == 32'h0));

  p_store_masked_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> ctrl_word == ($past(wdata) & ~WR_DROP_MASK));

  p_icfg_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word_acc && addr == ADDR_W'(OFF_ICFG)) |=> rdata == ICFG_WORD);

  p_dcfg_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && word_acc && addr == ADDR_W'(OFF_DCFG)) |=> rdata == DCFG_WORD);

  p_bad_size_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !word_acc) |=> (rvalid && rdata == 32'h0));

  p_ifreeze_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !wr_ctl && ctrl_word[4] && ctrl_word[1:0] == 2'b11)
      |=> ctrl_word[1:0] == 2'b01);

  p_dfreeze_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !wr_ctl && ctrl_word[5] && ctrl_word[3:2] == 2'b11)
      |=> ctrl_word[3:2] == 2'b01);

  p_upper_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !wr_ctl) |=> $stable(ctrl_word[31:4]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!irq_taken && !wr_ctl) |=> $stable(ctrl_word));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && irq_taken) |=> ctrl_word == ($past(wdata) & ~WR_DROP_MASK));

  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

  p_no_read_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (!rvalid && rdata == 32'h0));

endmodule

bind cache_ctl_regs cache_ctl_regs_chk #(
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .acc_size  (acc_size),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .wdata     (wdata),
  .irq_taken (irq_taken),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .ctrl_word (ctrl_word)
);

// File: tb/cache_ctl_regs_test.sv
module cache_ctl_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [2:0]  acc_size = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        irq_taken = 1'b0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [31:0] ctrl_word;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cache_ctl_regs uut (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .acc_size  (acc_size),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .irq_taken (irq_taken),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .ctrl_word (ctrl_word)
  );

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  a;
    logic [2:0]  sz;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,  8'h00, 3'd4, 32'hFFFF_FFFF, 32'h0,         4'd2}, // R2
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'hFF9E_3FFF, 4'd2}, // R2 masked bits
    '{OP_WR,  8'h00, 3'd4, 32'h0080_0033, 32'h0,         4'd2},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0080_0033, 4'd2}, // R2 bit 23 kept
    '{OP_WR,  8'h00, 3'd4, 32'h0000_003F, 32'h0,         4'd6},
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd6},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0035, 4'd6}, // R6 and R7
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd8},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0035, 4'd8}, // R8 frozen stays
    '{OP_WR,  8'h00, 3'd4, 32'h0000_001F, 32'h0,         4'd6},
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd6},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_001D, 4'd8}, // R8 data unarmed
    '{OP_WR,  8'h00, 3'd4, 32'h0000_002D, 32'h0,         4'd7},
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd7},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0025, 4'd7}, // R7 alone
    '{OP_WR,  8'h00, 3'd4, 32'h0000_003E, 32'h0,         4'd8},
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd8},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0036, 4'd8}, // R8 state 10 kept
    '{OP_WR,  8'h00, 3'd4, 32'h0000_0030, 32'h0,         4'd8},
    '{OP_IRQ, 8'h00, 3'd4, 32'h0,         32'h0,         4'd8},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0030, 4'd8}, // R8 disabled kept
    '{OP_RD,  8'h04, 3'd4, 32'h0,         32'h1022_0000, 4'd3}, // R3
    '{OP_RD,  8'h08, 3'd4, 32'h0,         32'h1822_0000, 4'd3},
    '{OP_WR,  8'h04, 3'd4, 32'hFFFF_FFFF, 32'h0,         4'd3},
    '{OP_WR,  8'h08, 3'd4, 32'h0000_0000, 32'h0,         4'd3},
    '{OP_RD,  8'h04, 3'd4, 32'h0,         32'h1022_0000, 4'd3},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0030, 4'd3},
    '{OP_WR,  8'h00, 3'd2, 32'h0000_0000, 32'h0,         4'd4}, // R4
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0030, 4'd4},
    '{OP_RD,  8'h00, 3'd1, 32'h0,         32'h0,         4'd4},
    '{OP_RD,  8'h04, 3'd2, 32'h0,         32'h0,         4'd4},
    '{OP_WR,  8'h0C, 3'd4, 32'hFFFF_FFFF, 32'h0,         4'd5}, // R5
    '{OP_RD,  8'h0C, 3'd4, 32'h0,         32'h0,         4'd5},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0030, 4'd5},
    '{OP_RD,  8'h10, 3'd4, 32'h0,         32'h0,         4'd5},
    '{OP_RD,  8'h02, 3'd4, 32'h0,         32'h0,         4'd5},
    '{OP_WR,  8'h01, 3'd4, 32'hFFFF_FFFF, 32'h0,         4'd5},
    '{OP_RD,  8'h00, 3'd4, 32'h0,         32'h0000_0030, 4'd5}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    wr_en = 1'b0; rd_en = 1'b0; irq_taken = 1'b0;
    addr = '0; acc_size = '0; wdata = '0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [2:0] sz,
                          input logic [31:0] d, input logic irq);
    @(negedge clk);
    addr = a; acc_size = sz; wdata = d; wr_en = 1'b1; irq_taken = irq;
    @(negedge clk);
    drive_idle();
  endtask

  task automatic do_irq();
    @(negedge clk);
    irq_taken = 1'b1;
    @(negedge clk);
    drive_idle();
  endtask

  task automatic do_read(input logic [7:0] a, input logic [2:0] sz,
                         input logic [31:0] exp, input int req);
    @(negedge clk);
    addr = a; acc_size = sz; rd_en = 1'b1;
    @(negedge clk);
    chk(req, {31'h0, rvalid}, 32'h1);
    chk(req, rdata, exp);
    drive_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(1, ctrl_word, 32'h0);
    chk(1, {31'h0, rvalid}, 32'h0);
    chk(1, rdata, 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   do_write(VECS[i].a, VECS[i].sz, VECS[i].d, 1'b0);
        OP_IRQ:  do_irq();
        default: do_read(VECS[i].a, VECS[i].sz, VECS[i].e, int'(VECS[i].req));
      endcase
    end

    // R9: write and interrupt in one cycle, write must win
    do_write(8'h00, 3'd4, 32'h0000_003F, 1'b0);
    do_write(8'h00, 3'd4, 32'h0000_003F, 1'b1);
    do_read(8'h00, 3'd4, 32'h0000_003F, 9);
    chk(9, ctrl_word, 32'h0000_003F);

    // R10: read and write together return old contents, then rvalid drops
    @(negedge clk);
    addr = 8'h00; acc_size = 3'd4; wdata = 32'h0000_0012;
    wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    chk(10, {31'h0, rvalid}, 32'h1);
    chk(10, rdata, 32'h0000_003F);
    drive_idle();
    @(negedge clk);
    chk(10, {31'h0, rvalid}, 32'h0);
    chk(10, rdata, 32'h0);
    do_read(8'h00, 3'd4, 32'h0000_0012, 10);

    // R1: reset in mid-run clears the word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(1, ctrl_word, 32'h0);
    do_read(8'h00, 3'd4, 32'h0, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule